// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. Each start strobe runs one complete transaction. The engine sends an eight-bit request header, releases the bidirectional data line for turnaround and collects a three-bit acknowledge from the target. It then moves one 32-bit word in either direction and returns the line to an idle level. The data line leaves the block as three signals: output value, output enable and input. The link clock is generated inside the block from a programmable divider.

Configuration is captured at the start strobe. It sets the turnaround length, the number of low idle clocks after a successful transfer, whether dummy data phases follow a WAIT or FAULT answer, and the divider. On an acknowledge outside the three legal codes, the engine backs off for a fixed window before it drives the line again.

A separate line-sequence command clocks out an arbitrary bit string with the driver on. It is used for line resets and protocol switch patterns.

Top module: `swd_xfer_engine`

## Requirements
- R1: A transfer starts with eight driven cells in this order: 1, req[0], req[1], req[2], req[3], even parity of req[3:0], 0, 1. Here req[0] selects access port versus debug port, and req[1]=1 means read.
- R2: After the header, swdio_oe is low for cfg_turn+1 cells. Then three acknowledge cells are sampled with swdio_oe low, least significant bit first. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100, and status reports the code zero-extended to 4 bits.
- R3: On an OK read, 32 data cells are sampled LSB first, then one parity cell, then cfg_turn+1 released cells. rdata takes the 32 sampled bits.
- R4: On an OK read whose parity cell does not give even parity over data plus parity, status becomes 4'b1000. rdata still takes the sampled word.
- R5: On an OK write, cfg_turn+1 released cells come first. Then 32 driven cells carry wdata LSB first, and one driven cell carries the even parity of wdata.
- R6: After an OK read or write, cfg_idle cells are driven low. When the transaction ends, swdio is left driven high.
- R7: On WAIT or FAULT, a read with cfg_dphase=1 gets 33 released cells before cfg_turn+1 released cells. A read with cfg_dphase=0 gets only the turnaround cells. A write gets cfg_turn+1 released cells, followed by 33 cells driven low when cfg_dphase=1.
- R8: On any other acknowledge value, cfg_turn+1+33 released cells follow. The driver then comes back on with swdio high.
- R9: Each cell has a low swclk half followed by a high half, each cfg_div+1 clock cycles long. swdio_o and swdio_oe change only when swclk falls.
- R10: After reset and between transactions, swclk is high, swdio_oe is high, swdio_o is high and busy is low. busy rises in the cycle after an accepted strobe and stays high through the single-cycle done pulse.
- R11: start and seq_start are ignored while busy. When both are given together in idle, the transfer is run and the sequence is dropped.
- R12: seq_start clocks out seq_len driven cells carrying seq_data LSB first, leaving status and rdata unchanged. seq_len=0 produces no clock and an immediate done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer strobe |
| req | input | 4 | Request: [0] port select, [1] read, [3:2] register address |
| wdata | input | 32 | Write word |
| seq_start | input | 1 | Line-sequence strobe |
| seq_len | input | SEQ_LEN_W | Number of sequence bits, 0 to SEQ_MAX |
| seq_data | input | SEQ_MAX | Sequence bits, bit 0 sent first |
| cfg_turn | input | TURN_W | Turnaround cells minus one |
| cfg_idle | input | IDLE_W | Low idle cells after an OK transfer |
| cfg_dphase | input | 1 | Dummy data phase on WAIT/FAULT |
| cfg_div | input | DIV_W | Half-cell length minus one, in clk cycles |
| swclk | output | 1 | Link clock |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 4 | Acknowledge received, or 4'b1000 on read parity error |
| rdata | output | 32 | Last read word |

## Verification
The bench models the target cell by cell. It records the driver state and value at every rising link clock and compares the whole trace with one computed from the request, the acknowledge and the configuration. Any engine that mis-orders the header, miscounts turnaround, dummy, back-off or idle cells, or drives during a released cell therefore shows a count or cell mismatch. The corner cases it aims at are these: a corrupted read parity, which a faulty design would report as OK; both settings of the dummy-phase option for WAIT and FAULT on reads and on writes, where a wrong design would put the dummy cells on the wrong side of the turnaround; illegal acknowledges 3'b000 and 3'b111, which a wrong design might treat as OK and drive into a contending target; zero idle cells and zero-length sequences, which a wrong design would over-clock; and strobes during a transfer, which a faulty engine would act on as a second command.

// File: rtl/swd_xfer_pkg.sv
`timescale 1ns/1ps
package swd_xfer_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_TURN_A,
        ST_ACK,
        ST_RDATA,
        ST_TURN_B,
        ST_WDATA,
        ST_DUMMY_RD,
        ST_DUMMY_WR,
        ST_BACKOFF,
        ST_IDLE_CYC,
        ST_LINE_SEQ,
        ST_DONE
    } swd_state_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;
    localparam logic [3:0] STAT_PARITY_ERR = 4'b1000;

    localparam int WORD_W     = 32;
    localparam int HDR_CELLS  = 8;
    localparam int ACK_CELLS  = 3;
    localparam int WORD_CELLS = WORD_W + 1;

endpackage

// File: rtl/swd_cell_timer.sv
`timescale 1ns/1ps
module swd_cell_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             swclk,
    output logic             smp,
    output logic             fin
);

    logic             phase_hi;
    logic [DIV_W-1:0] cnt;
    logic             half_end;

    assign half_end = (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_hi <= 1'b0;
            cnt      <= '0;
        end else if (!run) begin
            phase_hi <= 1'b0;
            cnt      <= '0;
        end else if (half_end) begin
            cnt      <= '0;
            phase_hi <= ~phase_hi;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign swclk = !run || phase_hi;
    assign smp   = run && !phase_hi && half_end;
    assign fin   = run && phase_hi && half_end;

endmodule

// File: rtl/swd_even_par.sv
`timescale 1ns/1ps
module swd_even_par #(
    parameter int W = 32
) (
    input  logic [W-1:0] d,
    output logic         p
);

    assign p = ^d;

endmodule

// File: rtl/swd_xfer_engine.sv
`timescale 1ns/1ps
module swd_xfer_engine
    import swd_xfer_pkg::*;
#(
    parameter int TURN_W  = 2,
    parameter int IDLE_W  = 8,
    parameter int DIV_W   = 8,
    parameter int SEQ_MAX = 64,
    localparam int SEQ_LEN_W = $clog2(SEQ_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [3:0]           req,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 seq_start,
    input  logic [SEQ_LEN_W-1:0] seq_len,
    input  logic [SEQ_MAX-1:0]   seq_data,
    input  logic [TURN_W-1:0]    cfg_turn,
    input  logic [IDLE_W-1:0]    cfg_idle,
    input  logic                 cfg_dphase,
    input  logic [DIV_W-1:0]     cfg_div,
    output logic                 swclk,
    output logic                 swdio_o,
    output logic                 swdio_oe,
    input  logic                 swdio_i,
    output logic                 busy,
    output logic                 done,
    output logic [3:0]           status,
    output logic [WORD_W-1:0]    rdata
);

    localparam int SEQ_IDX_W = (SEQ_MAX > 1) ? $clog2(SEQ_MAX) : 1;
    localparam int BASE_W    = (IDLE_W > SEQ_LEN_W) ? IDLE_W : SEQ_LEN_W;
    localparam int CNT_W     = ((BASE_W > 7) ? BASE_W : 7) + TURN_W;

    swd_state_e state_q, state_d;

    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     cells;
    logic                 last;
    logic                 adv;
    logic                 run;
    logic                 smp;
    logic                 fin;

    logic [3:0]           req_q;
    logic [WORD_W-1:0]    wdata_q;
    logic [SEQ_MAX-1:0]   seq_q;
    logic [SEQ_LEN_W-1:0] seq_len_q;
    logic [TURN_W-1:0]    turn_q;
    logic [IDLE_W-1:0]    idle_q;
    logic                 dph_q;
    logic [DIV_W-1:0]     div_q;
    logic [2:0]           ack_sh;
    logic [WORD_W-1:0]    rd_sh;
    logic                 rpar_q;
    logic [3:0]           status_q;
    logic [WORD_W-1:0]    rdata_q;

    logic                 hdr_par;
    logic                 wr_par;
    logic                 rd_par;
    logic [7:0]           hdr_bits;
    logic                 ack_ok;
    logic                 ack_wf;
    logic                 rnw;
    logic                 idle_zero;

    swd_cell_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_q),
        .swclk (swclk),
        .smp   (smp),
        .fin   (fin)
    );

    swd_even_par #(.W(4))      u_hdr_par (.d(req_q),   .p(hdr_par));
    swd_even_par #(.W(WORD_W)) u_wr_par  (.d(wdata_q), .p(wr_par));
    swd_even_par #(.W(WORD_W)) u_rd_par  (.d(rd_sh),   .p(rd_par));

    assign hdr_bits  = {1'b1, 1'b0, hdr_par, req_q[3], req_q[2], req_q[1], req_q[0], 1'b1};
    assign ack_ok    = (ack_sh == ACK_OK);
    assign ack_wf    = (ack_sh == ACK_WAIT) || (ack_sh == ACK_FAULT);
    assign rnw       = req_q[1];
    assign idle_zero = (idle_q == '0);

    assign run  = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_DONE);

    // Number of cells spent in the current state.
    always_comb begin
        case (state_q)
            ST_HDR:      cells = CNT_W'(HDR_CELLS);
            ST_TURN_A,
            ST_TURN_B:   cells = CNT_W'(turn_q) + CNT_W'(1);
            ST_ACK:      cells = CNT_W'(ACK_CELLS);
            ST_RDATA,
            ST_WDATA,
            ST_DUMMY_RD,
            ST_DUMMY_WR: cells = CNT_W'(WORD_CELLS);
            ST_BACKOFF:  cells = CNT_W'(turn_q) + CNT_W'(1 + WORD_CELLS);
            ST_IDLE_CYC: cells = CNT_W'(idle_q);
            ST_LINE_SEQ: cells = CNT_W'(seq_len_q);
            default:     cells = CNT_W'(1);
        endcase
    end

    assign last = (cnt_q == cells - CNT_W'(1));
    assign adv  = fin && last;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)                  state_d = ST_HDR;
                else if (seq_start)         state_d = (seq_len == '0) ? ST_DONE : ST_LINE_SEQ;
            end
            ST_HDR:    if (adv) state_d = ST_TURN_A;
            ST_TURN_A: if (adv) state_d = ST_ACK;
            ST_ACK: begin
                if (adv) begin
                    if (ack_ok)             state_d = rnw ? ST_RDATA : ST_TURN_B;
                    else if (ack_wf)        state_d = (rnw && dph_q) ? ST_DUMMY_RD : ST_TURN_B;
                    else                    state_d = ST_BACKOFF;
                end
            end
            ST_RDATA:    if (adv) state_d = ST_TURN_B;
            ST_DUMMY_RD: if (adv) state_d = ST_TURN_B;
            ST_TURN_B: begin
                if (adv) begin
                    if (ack_ok && !rnw)     state_d = ST_WDATA;
                    else if (ack_ok)        state_d = idle_zero ? ST_DONE : ST_IDLE_CYC;
                    else if (!rnw && dph_q) state_d = ST_DUMMY_WR;
                    else                    state_d = ST_DONE;
                end
            end
            ST_WDATA:    if (adv) state_d = idle_zero ? ST_DONE : ST_IDLE_CYC;
            ST_DUMMY_WR: if (adv) state_d = ST_DONE;
            ST_BACKOFF:  if (adv) state_d = ST_DONE;
            ST_IDLE_CYC: if (adv) state_d = ST_DONE;
            ST_LINE_SEQ: if (adv) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Command capture, cell counting and sampling.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            req_q     <= '0;
            wdata_q   <= '0;
            seq_q     <= '0;
            seq_len_q <= '0;
            turn_q    <= '0;
            idle_q    <= '0;
            dph_q     <= 1'b0;
            div_q     <= '0;
            ack_sh    <= '0;
            rd_sh     <= '0;
            rpar_q    <= 1'b0;
            status_q  <= '0;
            rdata_q   <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                if (start) begin
                    req_q   <= req;
                    wdata_q <= wdata;
                    turn_q  <= cfg_turn;
                    idle_q  <= cfg_idle;
                    dph_q   <= cfg_dphase;
                    div_q   <= cfg_div;
                end else if (seq_start) begin
                    seq_q     <= seq_data;
                    seq_len_q <= seq_len;
                    div_q     <= cfg_div;
                end
            end else if (fin) begin
                cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
            end

            if (smp && state_q == ST_ACK) begin
                ack_sh <= {swdio_i, ack_sh[2:1]};
            end
            if (smp && state_q == ST_RDATA) begin
                if (cnt_q < CNT_W'(WORD_W)) rd_sh  <= {swdio_i, rd_sh[WORD_W-1:1]};
                else                        rpar_q <= swdio_i;
            end
            if (adv && state_q == ST_ACK) begin
                status_q <= {1'b0, ack_sh};
            end
            if (adv && state_q == ST_RDATA) begin
                rdata_q <= rd_sh;
                if (rd_par != rpar_q) status_q <= STAT_PARITY_ERR;
            end
        end
    end

    // Line outputs.
    always_comb begin
        swdio_oe = 1'b1;
        swdio_o  = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                swdio_oe = 1'b1;
                swdio_o  = 1'b1;
            end
            ST_HDR: begin
                swdio_oe = 1'b1;
                swdio_o  = hdr_bits[cnt_q[2:0]];
            end
            ST_TURN_A, ST_ACK, ST_RDATA, ST_DUMMY_RD, ST_TURN_B, ST_BACKOFF: begin
                swdio_oe = 1'b0;
                swdio_o  = 1'b1;
            end
            ST_WDATA: begin
                swdio_oe = 1'b1;
                swdio_o  = (cnt_q < CNT_W'(WORD_W)) ? wdata_q[cnt_q[4:0]] : wr_par;
            end
            ST_DUMMY_WR, ST_IDLE_CYC: begin
                swdio_oe = 1'b1;
                swdio_o  = 1'b0;
            end
            ST_LINE_SEQ: begin
                swdio_oe = 1'b1;
                swdio_o  = seq_q[cnt_q[SEQ_IDX_W-1:0]];
            end
            default: begin
                swdio_oe = 1'b1;
                swdio_o  = 1'b1;
            end
        endcase
    end

    assign status = status_q;
    assign rdata  = rdata_q;

endmodule

// File: rtl/swd_xfer_checker.sv
`timescale 1ns/1ps
module swd_xfer_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic swclk,
    input logic swdio_o,
    input logic swdio_oe
);

    // R9: line outputs hold while the link clock stays high inside a command
    a_r9_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && swclk && $past(swclk) && $past(busy))
            |-> ($stable(swdio_o) && $stable(swdio_oe)));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done only while busy
    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10: idle line level
    a_r10_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swclk && swdio_oe && swdio_o));

    // R2: the driver is released only inside a running command
    a_r2_release_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !swdio_oe |-> (busy && !done));

endmodule

bind swd_xfer_engine swd_xfer_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .swclk    (swclk),
    .swdio_o  (swdio_o),
    .swdio_oe (swdio_oe)
);

// File: tb/swd_xfer_engine_bench.sv
`timescale 1ns/1ps
module swd_xfer_engine_bench;

    localparam int TURN_W    = 2;
    localparam int IDLE_W    = 8;
    localparam int DIV_W     = 8;
    localparam int SEQ_MAX   = 64;
    localparam int SEQ_LEN_W = $clog2(SEQ_MAX + 1);
    localparam int MAXC      = 512;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [3:0]           req = '0;
    logic [31:0]          wdata = '0;
    logic                 seq_start = 1'b0;
    logic [SEQ_LEN_W-1:0] seq_len = '0;
    logic [SEQ_MAX-1:0]   seq_data = '0;
    logic [TURN_W-1:0]    cfg_turn = '0;
    logic [IDLE_W-1:0]    cfg_idle = '0;
    logic                 cfg_dphase = 1'b0;
    logic [DIV_W-1:0]     cfg_div = '0;
    logic                 swclk;
    logic                 swdio_o;
    logic                 swdio_oe;
    logic                 swdio_i = 1'b1;
    logic                 busy;
    logic                 done;
    logic [3:0]           status;
    logic [31:0]          rdata;

    always #2 clk = ~clk;

    swd_xfer_engine #(
        .TURN_W(TURN_W), .IDLE_W(IDLE_W), .DIV_W(DIV_W), .SEQ_MAX(SEQ_MAX)
    ) u_swd_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .wdata(wdata),
        .seq_start(seq_start), .seq_len(seq_len), .seq_data(seq_data),
        .cfg_turn(cfg_turn), .cfg_idle(cfg_idle), .cfg_dphase(cfg_dphase),
        .cfg_div(cfg_div), .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
        .swdio_i(swdio_i), .busy(busy), .done(done), .status(status), .rdata(rdata)
    );

    int checks = 0;
    int fails  = 0;

    logic exp_oe [MAXC];
    logic exp_o  [MAXC];
    logic in_bits[MAXC];
    logic cap_oe [MAXC];
    logic cap_o  [MAXC];
    int   exp_n;
    int   cell_n;
    int   low_cnt;
    int   high_cnt;
    bit   armed = 1'b0;

    // Target model: present the next input bit at the start of each cell.
    always @(negedge swclk) begin
        if (armed) begin
            if (cell_n < MAXC) swdio_i = in_bits[cell_n];
            cell_n = cell_n + 1;
        end
    end

    // Record the line at the rising edge of each cell.
    always @(posedge swclk) begin
        if (armed && cell_n > 0 && cell_n <= MAXC) begin
            cap_oe[cell_n-1] = swdio_oe;
            cap_o[cell_n-1]  = swdio_o;
        end
    end

    always @(negedge clk) begin
        if (armed && busy) begin
            if (!swclk)     low_cnt  = low_cnt + 1;
            else if (!done) high_cnt = high_cnt + 1;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic oe, input logic o);
        exp_oe[exp_n] = oe;
        exp_o[exp_n]  = o;
        exp_n++;
    endtask

    task automatic clear_model();
        exp_n = 0;
        for (int i = 0; i < MAXC; i++) in_bits[i] = 1'b1;
    endtask

    // Expected cell trace for one transfer (R1 to R8).
    task automatic build_xfer(input logic [3:0] rq, input logic [31:0] wd,
                              input logic [2:0] ak, input logic [31:0] rd,
                              input bit badp, input int t, input int idl,
                              input bit dph, output logic [3:0] est);
        clear_model();
        push(1'b1, 1'b1);
        for (int i = 0; i < 4; i++) push(1'b1, rq[i]);
        push(1'b1, ^rq);
        push(1'b1, 1'b0);
        push(1'b1, 1'b1);
        repeat (t) push(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            in_bits[exp_n] = ak[i];
            push(1'b0, 1'b1);
        end
        est = {1'b0, ak};
        if (ak == 3'b001) begin
            if (rq[1]) begin
                for (int i = 0; i < 32; i++) begin
                    in_bits[exp_n] = rd[i];
                    push(1'b0, 1'b1);
                end
                in_bits[exp_n] = (^rd) ^ badp;
                push(1'b0, 1'b1);
                repeat (t) push(1'b0, 1'b1);
                if (badp) est = 4'b1000;
            end else begin
                repeat (t) push(1'b0, 1'b1);
                for (int i = 0; i < 32; i++) push(1'b1, wd[i]);
                push(1'b1, ^wd);
            end
            repeat (idl) push(1'b1, 1'b0);
        end else if (ak == 3'b010 || ak == 3'b100) begin
            if (rq[1] && dph) repeat (33) push(1'b0, 1'b1);
            repeat (t) push(1'b0, 1'b1);
            if (!rq[1] && dph) repeat (33) push(1'b1, 1'b0);
        end else begin
            repeat (t + 33) push(1'b0, 1'b1);
        end
    endtask

    task automatic compare_cells(input string tag, input int dv);
        int mis = 0;
        int lim = (cell_n < exp_n) ? cell_n : exp_n;
        for (int i = 0; i < lim; i++) begin
            if (cap_oe[i] !== exp_oe[i] || (exp_oe[i] && cap_o[i] !== exp_o[i])) mis++;
        end
        chk(tag, "cell count", 64'(cell_n), 64'(exp_n));
        chk(tag, "cell mismatches", 64'(mis), 64'd0);
        // R9: half-cell lengths
        chk({tag, " R9"}, "low cycles", 64'(low_cnt), 64'(exp_n * (dv + 1)));
        chk({tag, " R9"}, "high cycles", 64'(high_cnt), 64'(exp_n * (dv + 1)));
    endtask

    task automatic wait_done(input string tag, input bit poke, input logic [3:0] rq);
        int n = 0;
        while (!done && n < 20000) begin
            if (poke && n == 9) begin
                start = 1'b1; seq_start = 1'b1; req = ~rq; seq_len = 7'd12;
            end else begin
                start = 1'b0; seq_start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0; seq_start = 1'b0;
        chk(tag, "done seen", 64'(done), 64'd1);
        chk({tag, " R10"}, "busy at done", 64'(busy), 64'd1);
    endtask

    task automatic after_done(input string tag, input bit poke);
        @(negedge clk);
        chk({tag, " R6/R10"}, "line after done",
            {60'd0, busy, swclk, swdio_oe, swdio_o}, 64'b0111);
        if (poke) begin
            repeat (40) @(negedge clk);
            chk({tag, " R11"}, "no extra cells", 64'(cell_n), 64'(exp_n));
            chk({tag, " R11"}, "stays idle", 64'(busy), 64'd0);
        end
        armed = 1'b0;
    endtask

    task automatic run_xfer(input string tag, input logic [3:0] rq, input logic [31:0] wd,
                            input logic [2:0] ak, input logic [31:0] rd, input bit badp,
                            input int t, input int idl, input bit dph, input int dv,
                            input bit also_seq, input bit poke);
        logic [3:0]  est;
        logic [31:0] prev_rd = rdata;
        build_xfer(rq, wd, ak, rd, badp, t, idl, dph, est);
        cfg_turn = TURN_W'(t - 1); cfg_idle = IDLE_W'(idl);
        cfg_dphase = dph; cfg_div = DIV_W'(dv);
        req = rq; wdata = wd;
        seq_len = 7'd20; seq_data = {SEQ_MAX{1'b1}};
        cell_n = 0; low_cnt = 0; high_cnt = 0; armed = 1'b1;
        start = 1'b1; seq_start = also_seq;
        @(negedge clk);
        start = 1'b0; seq_start = 1'b0;
        wait_done(tag, poke, rq);
        compare_cells(tag, dv);
        chk(tag, "status", 64'(status), 64'(est));
        chk(tag, "rdata", 64'(rdata), 64'((ak == 3'b001 && rq[1]) ? rd : prev_rd));
        after_done(tag, poke);
    endtask

    task automatic run_seq(input string tag, input int len, input logic [SEQ_MAX-1:0] sd,
                           input int dv);
        logic [3:0]  prev_st = status;
        logic [31:0] prev_rd = rdata;
        clear_model();
        for (int i = 0; i < len; i++) push(1'b1, sd[i]);
        cfg_div = DIV_W'(dv); seq_len = SEQ_LEN_W'(len); seq_data = sd;
        cell_n = 0; low_cnt = 0; high_cnt = 0; armed = 1'b1;
        seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
        wait_done(tag, 1'b0, 4'd0);
        compare_cells(tag, dv);
        chk(tag, "status kept", 64'(status), 64'(prev_st));
        chk(tag, "rdata kept", 64'(rdata), 64'(prev_rd));
        after_done(tag, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [2:0] ak_tab [6];
        ak_tab[0] = 3'b001; ak_tab[1] = 3'b001; ak_tab[2] = 3'b010;
        ak_tab[3] = 3'b100; ak_tab[4] = 3'b111; ak_tab[5] = 3'b000;
        void'($urandom(32'd715));

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "reset line", {60'd0, busy, swclk, swdio_oe, swdio_o}, 64'b0111);
        chk("R10", "reset done", 64'(done), 64'd0);
        chk("R2", "reset status", 64'(status), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_xfer("R1/R3 ok read",     4'b0010, 32'h0, 3'b001, 32'hDEADBEEF, 1'b0, 1, 0, 1'b0, 0, 1'b0, 1'b0);
        run_xfer("R4 parity error",   4'b1011, 32'h0, 3'b001, 32'h12345678, 1'b1, 2, 2, 1'b0, 1, 1'b0, 1'b0);
        run_xfer("R5/R6 ok write",    4'b0101, 32'hA5C3_0F81, 3'b001, 32'h0, 1'b0, 1, 4, 1'b0, 0, 1'b0, 1'b0);
        run_xfer("R5/R6 write idle0", 4'b1100, 32'h8000_0001, 3'b001, 32'h0, 1'b0, 4, 0, 1'b0, 0, 1'b0, 1'b0);
        run_xfer("R7 wait read dph",  4'b0010, 32'h0, 3'b010, 32'h0, 1'b0, 2, 3, 1'b1, 0, 1'b0, 1'b0);
        run_xfer("R7 wait read",      4'b0011, 32'h0, 3'b010, 32'h0, 1'b0, 1, 3, 1'b0, 0, 1'b0, 1'b0);
        run_xfer("R7 fault write dph",4'b0100, 32'hFFFF_FFFF, 3'b100, 32'h0, 1'b0, 3, 3, 1'b1, 0, 1'b0, 1'b0);
        run_xfer("R7 fault write",    4'b0001, 32'h1, 3'b100, 32'h0, 1'b0, 1, 3, 1'b0, 0, 1'b0, 1'b0);
        run_xfer("R8 ack 111",        4'b0010, 32'h0, 3'b111, 32'h0, 1'b0, 2, 3, 1'b1, 0, 1'b0, 1'b0);
        run_xfer("R8 ack 000",        4'b1000, 32'h0, 3'b000, 32'h0, 1'b0, 1, 3, 1'b1, 0, 1'b0, 1'b0);
        run_xfer("R9 slow clock",     4'b0110, 32'h0, 3'b001, 32'h0F0F_55AA, 1'b0, 1, 1, 1'b0, 3, 1'b0, 1'b0);
        run_xfer("R11 busy strobes",  4'b0000, 32'h1357_9BDF, 3'b001, 32'h0, 1'b0, 1, 2, 1'b0, 0, 1'b0, 1'b1);
        run_xfer("R11 start wins",    4'b1110, 32'h0, 3'b001, 32'hCAFE_F00D, 1'b0, 1, 0, 1'b0, 0, 1'b1, 1'b0);

        run_seq("R12 seq 50", 50, 64'h0003_FFFF_FFFF_FFFF ^ 64'h0000_9E37_79B9_7F4A, 0);
        run_seq("R12 seq 0", 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        run_seq("R12 seq 64", 64, 64'hE7A1_0000_FFFF_3C3C, 1);

        for (int k = 0; k < 24; k++) begin
            logic [3:0]  rq = 4'($urandom % 16);
            logic [31:0] wd = $urandom;
            logic [31:0] rd = $urandom;
            logic [2:0]  ak = ak_tab[$urandom % 6];
            bit          bp = (($urandom % 4) == 0);
            int          t  = 1 + int'($urandom % 4);
            int          il = int'($urandom % 6);
            bit          dp = 1'($urandom % 2);
            int          dv = int'($urandom % 3);
            run_xfer("R1/R2/R3/R5/R7/R8 random", rq, wd, ak, rd, bp, t, il, dp, dv, 1'b0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule